// File: doc/BRIEF.md
# Issue Slot Waste Classifier

This block is a performance monitor for a wide instruction issue stage. Each clock cycle it receives a mask with one bit per issue slot, set when that slot carried an instruction. It counts the filled slots and sorts every empty slot into one of two classes. In a cycle where nothing issued, all slots are whole-cycle (vertical) waste. In a cycle where some but not all slots issued, the empty slots are partial-cycle (horizontal) waste.

Five saturating counters record this activity: observed cycles, filled slots, vertical-waste slots, horizontal-waste slots and fully idle cycles. Software reads any one of them through a combinational select port. A synchronous clear zeroes all five at once. An enable input freezes counting, so software can bracket a measurement window. The block does not find the cause of a stall and does not compute ratios.

Top module: `slot_waste_mon`

## Requirements
- R1: After reset, every counter reads zero.
- R2: Each cycle with the count enable high and clear low adds one to the cycle counter.
- R3: In a counted cycle, the filled-slot counter grows by the number of set bits in the valid mask (bit i high means slot i issued).
- R4: In a counted cycle with an all-zero mask, the vertical-waste counter grows by the slot count (8), the idle-cycle counter grows by one, and the horizontal-waste counter does not change.
- R5: In a counted cycle with between one and seven mask bits set, the horizontal-waste counter grows by the number of clear bits. A fully set mask adds to neither waste counter.
- R6: When no counter has saturated, filled plus vertical plus horizontal equals the slot count times the cycle counter.
- R7: Every counter saturates at its all-ones value and never wraps.
- R8: A clear request zeroes all counters at the next edge and takes priority over counting in that cycle.
- R9: With the count enable low, no counter changes, whatever the mask holds.
- R10: The read data follows the 3-bit select combinationally: 0 selects cycles, 1 filled slots, 2 vertical waste, 3 horizontal waste, 4 idle cycles, and 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countEn | input | 1 | Counting enable; when low, all counters hold |
| clearReq | input | 1 | Synchronous clear of all counters |
| slotValid | input | SLOT_COUNT | Per-slot issued mask for this cycle |
| readSel | input | 3 | Counter select for the read port |
| readData | output | CNT_WIDTH | Selected counter value |

## Verification
The bench builds the block with 8 slots and a counter width of 8 bits instead of 32. This puts the all-ones limit at 255, which 40 idle cycles push the vertical-waste counter past, so saturation is reached within a few dozen cycles. Keeping 8 slots means the mask table covers the idle, partial and full-issue classes at the same width as the default build.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int NUM_CNT = 5;
  localparam int SEL_W   = 3;

  localparam int CNT_CYCLES = 0;
  localparam int CNT_FILLED = 1;
  localparam int CNT_VERT   = 2;
  localparam int CNT_HORIZ  = 3;
  localparam int CNT_IDLE   = 4;

  typedef struct packed {
    logic clear;
    logic tick;
    logic idleCyc;
    logic partialCyc;
  } swm_strobe_t;
endpackage

// File: rtl/swm_satcnt.sv
module swm_satcnt #(
  parameter int W  = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  logic [W:0] sumExt;

  always_comb begin
    sumExt = {1'b0, cnt} + {{(W+1-IW){1'b0}}, inc};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (sumExt[W]) cnt <= '1;
    else                cnt <= sumExt[W-1:0];
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> cnt >= $past(cnt));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == '0);
endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
  import swm_pkg::*;
#(
  parameter int SLOT_COUNT = 8,
  localparam int AMT_W = $clog2(SLOT_COUNT + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  countEn,
  input  logic                  clearReq,
  input  logic [SLOT_COUNT-1:0] slotValid,
  output swm_strobe_t           strobe,
  output logic [AMT_W-1:0]      filledAmt,
  output logic [AMT_W-1:0]      emptyAmt
);
  always_comb begin
    filledAmt = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      filledAmt = filledAmt + AMT_W'(slotValid[i]);
    end
    emptyAmt = AMT_W'(SLOT_COUNT) - filledAmt;
  end

  always_comb begin
    strobe.clear      = clearReq;
    strobe.tick       = countEn && !clearReq;
    strobe.idleCyc    = strobe.tick && (filledAmt == '0);
    strobe.partialCyc = strobe.tick && (filledAmt != '0) &&
                        (filledAmt != AMT_W'(SLOT_COUNT));
  end

  // R4
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idleCyc |-> (slotValid == '0));

  // R5
  partial_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.partialCyc |-> (slotValid != '0) && (~slotValid != '0));

  // R9
  freeze_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |-> !strobe.tick && !strobe.idleCyc && !strobe.partialCyc);
endmodule

// File: rtl/swm_dpath.sv
module swm_dpath
  import swm_pkg::*;
#(
  parameter int SLOT_COUNT = 8,
  parameter int CNT_WIDTH  = 32,
  localparam int AMT_W = $clog2(SLOT_COUNT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swm_strobe_t          strobe,
  input  logic [AMT_W-1:0]     filledAmt,
  input  logic [AMT_W-1:0]     emptyAmt,
  input  logic [SEL_W-1:0]     readSel,
  output logic [CNT_WIDTH-1:0] readData
);
  logic [NUM_CNT-1:0][AMT_W-1:0]     incVal;
  logic [NUM_CNT-1:0][CNT_WIDTH-1:0] cntVal;

  always_comb begin
    incVal             = '0;
    incVal[CNT_CYCLES] = strobe.tick ? AMT_W'(1) : '0;
    incVal[CNT_FILLED] = strobe.tick ? filledAmt : '0;
    incVal[CNT_VERT]   = strobe.idleCyc ? AMT_W'(SLOT_COUNT) : '0;
    incVal[CNT_HORIZ]  = strobe.partialCyc ? emptyAmt : '0;
    incVal[CNT_IDLE]   = strobe.idleCyc ? AMT_W'(1) : '0;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    swm_satcnt #(.W(CNT_WIDTH), .IW(AMT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobe.clear),
      .inc  (incVal[g]),
      .cnt  (cntVal[g])
    );
  end

  always_comb begin
    readData = '0;
    if (int'(readSel) < NUM_CNT) readData = cntVal[readSel];
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clear) |=> $stable(cntVal));

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && cntVal[CNT_CYCLES] != '1) |=>
      cntVal[CNT_CYCLES] == $past(cntVal[CNT_CYCLES]) + 1'b1);
endmodule

// File: rtl/slot_waste_mon.sv
module slot_waste_mon
  import swm_pkg::*;
#(
  parameter int SLOT_COUNT = 8,
  parameter int CNT_WIDTH  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  countEn,
  input  logic                  clearReq,
  input  logic [SLOT_COUNT-1:0] slotValid,
  input  logic [2:0]            readSel,
  output logic [CNT_WIDTH-1:0]  readData
);
  localparam int AMT_W = $clog2(SLOT_COUNT + 1);

  swm_strobe_t      strobe;
  logic [AMT_W-1:0] filledAmt;
  logic [AMT_W-1:0] emptyAmt;

  swm_ctrl #(.SLOT_COUNT(SLOT_COUNT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .countEn   (countEn),
    .clearReq  (clearReq),
    .slotValid (slotValid),
    .strobe    (strobe),
    .filledAmt (filledAmt),
    .emptyAmt  (emptyAmt)
  );

  swm_dpath #(.SLOT_COUNT(SLOT_COUNT), .CNT_WIDTH(CNT_WIDTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .filledAmt (filledAmt),
    .emptyAmt  (emptyAmt),
    .readSel   (readSel),
    .readData  (readData)
  );
endmodule

// File: tb/slot_waste_mon_bench.sv
`timescale 1ns/1ps
module slot_waste_mon_bench;
  localparam int SLOTS = 8;
  localparam int CW    = 8;
  localparam int NVEC  = 10;

  typedef struct packed {
    logic [7:0] mask;
    logic [3:0] dFill;
    logic [3:0] dVert;
    logic [3:0] dHoriz;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 4'd0, 4'd8, 4'd0},
    '{8'hFF, 4'd8, 4'd0, 4'd0},
    '{8'h01, 4'd1, 4'd0, 4'd7},
    '{8'h80, 4'd1, 4'd0, 4'd7},
    '{8'h0F, 4'd4, 4'd0, 4'd4},
    '{8'hAA, 4'd4, 4'd0, 4'd4},
    '{8'h7F, 4'd7, 4'd0, 4'd1},
    '{8'hFE, 4'd7, 4'd0, 4'd1},
    '{8'h00, 4'd0, 4'd8, 4'd0},
    '{8'h3C, 4'd4, 4'd0, 4'd4}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0;
  logic clearReq = 1'b0;
  logic [SLOTS-1:0] slotValid = '0;
  logic [2:0] readSel = '0;
  logic [CW-1:0] readData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  int expCyc = 0, expFill = 0, expVert = 0, expHoriz = 0, expIdle = 0;

  always #2.5 clk = ~clk;

  slot_waste_mon #(.SLOT_COUNT(SLOTS), .CNT_WIDTH(CW)) u_slot_waste_mon (
    .clk, .rstN, .countEn, .clearReq, .slotValid, .readSel, .readData
  );

  task automatic check(input string tag, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic readCnt(input int sel, output int val);
    readSel = 3'(sel);
    #0.5;
    val = int'(readData);
  endtask

  task automatic checkAll(input string tag);
    int v;
    readCnt(0, v); check({tag, " cycles"}, v, expCyc);
    readCnt(1, v); check({tag, " filled"}, v, expFill);
    readCnt(2, v); check({tag, " vertical"}, v, expVert);
    readCnt(3, v); check({tag, " horizontal"}, v, expHoriz);
    readCnt(4, v); check({tag, " idle"}, v, expIdle);
  endtask

  task automatic step(input logic en, input logic clr, input logic [7:0] m);
    @(negedge clk);
    countEn = en; clearReq = clr; slotValid = m;
    @(negedge clk);
    countEn = 1'b0; clearReq = 1'b0; slotValid = '0;
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state and R10 unused selects
    checkAll("R1 reset");
    for (int s = 5; s < 8; s++) begin
      readCnt(s, v); check("R10 unused select", v, 0);
    end

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, 1'b0, VECS[i].mask);
      expCyc++; expFill += VECS[i].dFill; expVert += VECS[i].dVert;
      expHoriz += VECS[i].dHoriz;
      if (VECS[i].dVert != 0) expIdle++;
      checkAll($sformatf("R2-5 vec%0d", i));
    end

    // R6 conservation of slots
    check("R6 sum", expFill + expVert + expHoriz, SLOTS * expCyc);
    begin
      int a, b, c, d;
      readCnt(1, a); readCnt(2, b); readCnt(3, c); readCnt(0, d);
      check("R6 sum", a + b + c, SLOTS * d);
    end

    // R9 enable low freezes counters
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h5A);
    step(1'b0, 1'b0, 8'hFF);
    checkAll("R9 frozen");

    // R8 clear wins over counting
    step(1'b1, 1'b1, 8'h00);
    expCyc = 0; expFill = 0; expVert = 0; expHoriz = 0; expIdle = 0;
    checkAll("R8 clear");

    // R7 saturation
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 8'h00);
    end
    expCyc = 40; expVert = sat(320); expIdle = 40;
    checkAll("R7 saturate");
    step(1'b1, 1'b0, 8'h00);
    expCyc = 41; expIdle = 41;
    checkAll("R7 hold at max");

    // R5 full issue adds no waste
    step(1'b1, 1'b0, 8'hFF);
    expCyc = 42; expFill = 8;
    checkAll("R5 full issue");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule